// File: doc/BRIEF.md
# LED Matrix Column Scanner with Brightness Control

This block scans a 16-row by 8-column LED matrix one column at a time. Each column gets a slot of fixed length. The slot opens with an ON phase: one anode line is driven and the 16 row lines carry that column's pixels. The rest of the slot is a dark phase, in which every anode and every row is low. A 4-bit level sets the length of the ON phase through a 16-entry duration table. The level therefore controls brightness, and the scan rate stays the same at every level.

Pixels come from two 16-byte frame buffers held outside the block, a main image and an alternate image. Each buffer has its own read port with a one-cycle read latency. Byte r holds row r, with row 0 at the top, and bit 7 of each byte is the leftmost column. During each slot the block reads the next column's data from both buffers into shadow registers. At the slot boundary it takes the level and the buffer select from its inputs, so a slot never mixes two settings. A pulse marks the start of every slot and another marks the start of every frame, so that outside logic can update the buffers in step with the scan. With a 48 MHz clock, the default parameters give slots about 833 µs long (1200 Hz) and a 150 Hz frame rate.

Top module: `ledm_scan_top`

## Requirements
- R1: While reset is asserted, and after reset until the first slot begins, `anode`, `rows`, `slot_tick` and `frame_tick` are all zero.
- R2: During an ON phase exactly one anode bit is set. The column-0 slot drives 8'b1000_0000, and each later slot moves the bit one place toward bit 0. After column 7 the scan wraps to column 0.
- R3: Every slot lasts exactly SLOT_CYCLES cycles, whatever the level. `slot_tick` is high only in the first cycle of each slot.
- R4: `frame_tick` is high only in the first cycle of the column-0 slot.
- R5: The ON phase starts in the first cycle of the slot and lasts ON_TABLE[level] cycles. Entry b sits at bits [32b+31:32b] of ON_TABLE. The default entry is (b+1)×UNIT_CYCLES, and each entry must lie between 1 and SLOT_CYCLES−1.
- R6: For the rest of the slot after the ON phase, `anode` and `rows` are both zero.
- R7: In the slot for column c, `rows[r]` equals bit (7−c) of buffer byte r.
- R8: When `show_alt` is 1 at the slot boundary, the slot shows the alternate buffer. When it is 0, the slot shows the main buffer.
- R9: `level` and `show_alt` are sampled only on the clock edge that ends the last cycle of a slot. A change at any other time has no effect on the current slot.
- R10: In the first 16 cycles of every slot, both read ports present addresses 0 to 15 in ascending order, one per cycle. The data returned during that slot is what the next slot displays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| level | input | 4 | Brightness level, 0 dimmest to 15 brightest |
| show_alt | input | 1 | 1 selects the alternate frame buffer |
| main_addr | output | 4 | Row address to the main buffer |
| main_data | input | 8 | Main buffer byte, valid one cycle after its address |
| alt_addr | output | 4 | Row address to the alternate buffer |
| alt_data | input | 8 | Alternate buffer byte, valid one cycle after its address |
| anode | output | 8 | One-hot column drive, bit 7 is the leftmost column |
| rows | output | 16 | Row drive, bit 0 is the top row |
| slot_tick | output | 1 | Pulse in the first cycle of every slot |
| frame_tick | output | 1 | Pulse in the first cycle of the column-0 slot |

## Verification
Results appear in the cycle after the clock edge that causes them, and the bench samples every output on the falling clock edge.

Level and buffer select are sampled on the edge that closes a slot, so their effect is first visible in cycle 0 of the next slot. The bench changes both inputs in cycle 3 of a slot and expects the old values for the remainder of that slot.

Buffer data reaches the display one slot late. The read addresses are checked in cycles 0 to 15. The expected column for the next slot is taken from the bench's memory model in cycle 18, after the last byte has been read. The memory is rewritten only in the last cycle of a slot, so the following slot must still show the old contents.

// File: rtl/ledm_pkg.sv
package ledm_pkg;
  localparam int LVLS = 16;
  localparam int LVLW = $clog2(LVLS);
  localparam int ENTW = 32;

  function automatic logic [LVLS*ENTW-1:0] linear_on_table(input int unit);
    logic [LVLS*ENTW-1:0] t;
    t = '0;
    for (int b = 0; b < LVLS; b++) begin
      t[b*ENTW +: ENTW] = ENTW'((b + 1) * unit);
    end
    return t;
  endfunction
endpackage

// File: rtl/ledm_rst_sync.sv
module ledm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ledm_slot_timer.sv
module ledm_slot_timer #(
  parameter int SLOT_CYCLES = 40000,
  parameter int COLS        = 8,
  localparam int CW   = $clog2(SLOT_CYCLES),
  localparam int COLW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prime_done,
  output logic            run,
  output logic [CW-1:0]   cnt,
  output logic [COLW-1:0] col,
  output logic [COLW-1:0] col_next,
  output logic            load
);
  logic            run_q, run_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [COLW-1:0] col_q, col_d;
  logic            en;

  // slot boundary: last cycle of a running slot, or end of the priming fetch
  assign load = run_q ? (cnt_q == CW'(SLOT_CYCLES - 1)) : prime_done;
  assign en   = load | run_q;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    col_d = col_q;
    if (load) begin
      run_d = 1'b1;
      cnt_d = '0;
      if (!run_q || col_q == COLW'(COLS - 1)) col_d = '0;
      else                                    col_d = col_q + COLW'(1);
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      col_q <= '0;
    end else if (en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      col_q <= col_d;
    end
  end

  assign run      = run_q;
  assign cnt      = cnt_q;
  assign col      = col_q;
  assign col_next = col_d;
endmodule

// File: rtl/ledm_col_fetch.sv
module ledm_col_fetch #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int AW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COLW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [COLW-1:0] tgt_col,
  input  logic [COLS-1:0] main_data,
  input  logic [COLS-1:0] alt_data,
  output logic [AW-1:0]   rd_addr,
  output logic [ROWS-1:0] shadow_main,
  output logic [ROWS-1:0] shadow_alt,
  output logic            done
);
  logic            busy_q, busy_d;
  logic [AW-1:0]   idx_q, idx_d;
  logic [COLW-1:0] fcol_q, fcol_d;
  logic            cap_q;
  logic [AW-1:0]   cap_row_q;
  logic            done_q, done_d;
  logic [ROWS-1:0] shm_q, shm_d, sha_q, sha_d;
  logic [COLW-1:0] bsel;

  assign bsel = COLW'(COLS - 1) - fcol_q;

  // issue side: one address per cycle while busy
  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    fcol_d = fcol_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      fcol_d = tgt_col;
    end else if (busy_q) begin
      if (idx_q == AW'(ROWS - 1)) busy_d = 1'b0;
      else                        idx_d  = idx_q + AW'(1);
    end
  end

  // capture side: data arrives one cycle after its address
  always_comb begin
    shm_d  = shm_q;
    sha_d  = sha_q;
    done_d = 1'b0;
    if (cap_q) begin
      shm_d[cap_row_q] = main_data[bsel];
      sha_d[cap_row_q] = alt_data[bsel];
      done_d           = (cap_row_q == AW'(ROWS - 1));
    end
  end

  // reset state primes a fetch of column 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b1;
      idx_q     <= '0;
      fcol_q    <= '0;
      cap_q     <= 1'b0;
      cap_row_q <= '0;
      done_q    <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      idx_q     <= idx_d;
      fcol_q    <= fcol_d;
      cap_q     <= busy_q;
      cap_row_q <= idx_q;
      done_q    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shm_q <= '0;
      sha_q <= '0;
    end else if (cap_q) begin
      shm_q <= shm_d;
      sha_q <= sha_d;
    end
  end

  assign rd_addr     = idx_q;
  assign shadow_main = shm_q;
  assign shadow_alt  = sha_q;
  assign done        = done_q;
endmodule

// File: rtl/ledm_level_lut.sv
module ledm_level_lut #(
  parameter int CW = 16,
  parameter logic [ledm_pkg::LVLS*ledm_pkg::ENTW-1:0] ON_TABLE =
    ledm_pkg::linear_on_table(1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [ledm_pkg::LVLW-1:0] level,
  output logic [CW-1:0]             on_len
);
  logic [CW-1:0] ent [ledm_pkg::LVLS];
  logic [CW-1:0] on_q, on_d;

  for (genvar i = 0; i < ledm_pkg::LVLS; i++) begin : g_ent
    assign ent[i] = ON_TABLE[i*ledm_pkg::ENTW +: CW];
  end

  assign on_d = ent[level];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    on_q <= '0;
    else if (load) on_q <= on_d;
  end

  assign on_len = on_q;
endmodule

// File: rtl/ledm_scan_top.sv
module ledm_scan_top #(
  parameter int ROWS        = 16,
  parameter int COLS        = 8,
  parameter int SLOT_CYCLES = 40000,
  parameter int UNIT_CYCLES = 2496,
  parameter logic [ledm_pkg::LVLS*ledm_pkg::ENTW-1:0] ON_TABLE =
    ledm_pkg::linear_on_table(UNIT_CYCLES),
  localparam int AW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COLW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CW   = $clog2(SLOT_CYCLES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ledm_pkg::LVLW-1:0] level,
  input  logic                      show_alt,
  output logic [AW-1:0]             main_addr,
  input  logic [COLS-1:0]           main_data,
  output logic [AW-1:0]             alt_addr,
  input  logic [COLS-1:0]           alt_data,
  output logic [COLS-1:0]           anode,
  output logic [ROWS-1:0]           rows,
  output logic                      slot_tick,
  output logic                      frame_tick
);
  logic            srst_n;
  logic            run, load, prime_done;
  logic [CW-1:0]   cnt, on_len;
  logic [COLW-1:0] col, col_next, fetch_col;
  logic [AW-1:0]   rd_addr;
  logic [ROWS-1:0] sh_main, sh_alt;
  logic [ROWS-1:0] row_q, row_d;
  logic            on_phase;

  ledm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  ledm_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES), .COLS(COLS)) u_timer (
    .clk(clk), .rst_n(srst_n), .prime_done(prime_done), .run(run),
    .cnt(cnt), .col(col), .col_next(col_next), .load(load)
  );

  // fetch one column ahead of the one being loaded
  assign fetch_col = (col_next == COLW'(COLS - 1)) ? '0 : col_next + COLW'(1);

  ledm_col_fetch #(.ROWS(ROWS), .COLS(COLS)) u_fetch (
    .clk(clk), .rst_n(srst_n), .start(load), .tgt_col(fetch_col),
    .main_data(main_data), .alt_data(alt_data), .rd_addr(rd_addr),
    .shadow_main(sh_main), .shadow_alt(sh_alt), .done(prime_done)
  );

  ledm_level_lut #(.CW(CW), .ON_TABLE(ON_TABLE)) u_lut (
    .clk(clk), .rst_n(srst_n), .load(load), .level(level), .on_len(on_len)
  );

  assign row_d = show_alt ? sh_alt : sh_main;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)   row_q <= '0;
    else if (load) row_q <= row_d;
  end

  assign on_phase = run && (cnt < on_len);

  for (genvar i = 0; i < COLS; i++) begin : g_anode
    assign anode[COLS-1-i] = on_phase && (col == COLW'(i));
  end

  assign rows       = on_phase ? row_q : '0;
  assign slot_tick  = run && (cnt == '0);
  assign frame_tick = slot_tick && (col == '0);
  assign main_addr  = rd_addr;
  assign alt_addr   = rd_addr;
endmodule

// File: rtl/ledm_scan_chk.sv
module ledm_scan_chk #(
  parameter int ROWS        = 16,
  parameter int COLS        = 8,
  parameter int SLOT_CYCLES = 40000
) (
  input logic            clk,
  input logic            rst_n,
  input logic [COLS-1:0] anode,
  input logic [ROWS-1:0] rows,
  input logic            slot_tick,
  input logic            frame_tick
);
  int   gap_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (slot_tick) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else if (gap_q < SLOT_CYCLES + 2) begin
      gap_q  <= gap_q + 1;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(anode));
  a_r2_hold_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_tick && anode != '0) |-> (anode == $past(anode)));
  a_r3_slot_period: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && seen_q) |-> (gap_q == SLOT_CYCLES - 1));
  a_r4_frame_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> slot_tick);
  a_r5_on_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |-> (anode != '0));
  a_r6_dark_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (anode == '0) |-> (rows == '0));
  a_r6_off_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_tick && $past(anode) == '0) |-> (anode == '0));
endmodule

bind ledm_scan_top ledm_scan_chk #(
  .ROWS(ROWS), .COLS(COLS), .SLOT_CYCLES(SLOT_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .anode(anode), .rows(rows),
  .slot_tick(slot_tick), .frame_tick(frame_tick)
);

// File: tb/ledm_scan_top_tb_top.sv
module ledm_scan_top_tb_top;
  localparam int ROWS = 16;
  localparam int COLS = 8;
  localparam int SLOT = 40;
  localparam int UNIT = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [3:0]  level;
  logic        show_alt;
  logic [3:0]  main_addr, alt_addr;
  logic [7:0]  main_data, alt_data;
  logic [7:0]  anode;
  logic [15:0] rows;
  logic        slot_tick, frame_tick;

  logic [7:0] mem_m [ROWS];
  logic [7:0] mem_a [ROWS];

  ledm_scan_top #(.ROWS(ROWS), .COLS(COLS), .SLOT_CYCLES(SLOT), .UNIT_CYCLES(UNIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .level(level), .show_alt(show_alt),
    .main_addr(main_addr), .main_data(main_data),
    .alt_addr(alt_addr), .alt_data(alt_data),
    .anode(anode), .rows(rows), .slot_tick(slot_tick), .frame_tick(frame_tick)
  );

  // buffer models: one-cycle read latency
  always @(posedge clk) begin
    main_data <= mem_m[main_addr];
    alt_data  <= mem_a[alt_addr];
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int col_e, lvl_cur;
  bit alt_cur, rewrote_prev;
  logic [15:0] shown_m, shown_a, snap_m, snap_a;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int r = 0; r < ROWS; r++) begin
      mem_m[r] = 8'((seed * 37) + (r * 11) + 5);
      mem_a[r] = mem_m[r] ^ 8'ha5;
    end
  endtask

  function automatic logic [15:0] column_bits(input bit alt, input int c);
    logic [15:0] v;
    for (int r = 0; r < ROWS; r++) begin
      if (alt) v[r] = mem_a[r][7-c];
      else     v[r] = mem_m[r][7-c];
    end
    return v;
  endfunction

  // entered at the falling edge inside cycle 0 of a slot
  task automatic do_slot(input int new_lvl, input bit new_alt, input int new_seed);
    int exp_on, on_meas, an_bad, off_bad, row_bad, tick_bad, addr_bad;
    logic [7:0]  exp_an, bad_an;
    logic [15:0] exp_rows, bad_rows;
    bit lvl_changed, alt_changed, wrote;
    string rreq;
    exp_on = (lvl_cur + 1) * UNIT;
    exp_an = 8'h80 >> col_e;
    exp_rows = alt_cur ? shown_a : shown_m;
    on_meas = 0; an_bad = 0; off_bad = 0; row_bad = 0; tick_bad = 0; addr_bad = 0;
    bad_an = '0; bad_rows = '0;
    lvl_changed = (new_lvl != lvl_cur);
    alt_changed = (new_alt != alt_cur);
    wrote = 1'b0;
    for (int k = 0; k < SLOT; k++) begin
      if (k == 0) begin
        chk(slot_tick == 1'b1, "R3", "slot_tick at slot start", slot_tick, 1);
        chk(frame_tick == (col_e == 0), "R4", "frame_tick at slot start", frame_tick, col_e == 0);
      end else if (slot_tick || frame_tick) begin
        tick_bad++;
      end
      if (anode != 0) on_meas++;
      if (k < exp_on) begin
        if (anode != exp_an) begin an_bad++; bad_an = anode; end
        if (rows != exp_rows) begin row_bad++; bad_rows = rows; end
      end else if (anode != 0 || rows != 0) begin
        off_bad++;
      end
      if (k < ROWS && (main_addr != 4'(k) || alt_addr != 4'(k))) addr_bad++;
      if (k == ROWS + 2) begin
        snap_m = column_bits(1'b0, (col_e + 1) % COLS);
        snap_a = column_bits(1'b1, (col_e + 1) % COLS);
      end
      if (k == 3) begin
        level    = 4'(new_lvl);
        show_alt = new_alt;
      end
      if (k == SLOT - 1 && new_seed >= 0) begin
        fill(new_seed);
        wrote = 1'b1;
      end
      @(negedge clk);
    end
    // R9: a mid-slot level change must not alter the current ON length
    chk(on_meas == exp_on, lvl_changed ? "R9" : "R5", "ON phase length", on_meas, exp_on);
    chk(an_bad == 0, "R2", "anode during ON phase", bad_an, exp_an);
    rreq = rewrote_prev ? "R10" : (alt_changed ? "R9" : (alt_cur ? "R8" : "R7"));
    chk(row_bad == 0, rreq, "rows during ON phase", bad_rows, exp_rows);
    chk(off_bad == 0, "R6", "dark phase cycles not dark", off_bad, 0);
    chk(tick_bad == 0, "R3", "ticks outside slot start", tick_bad, 0);
    chk(addr_bad == 0, "R10", "read address sequence errors", addr_bad, 0);
    col_e = (col_e + 1) % COLS;
    lvl_cur = int'(level);
    alt_cur = show_alt;
    shown_m = snap_m;
    shown_a = snap_a;
    rewrote_prev = wrote;
  endtask

  initial begin
    int wait_cnt;
    bit pre_bad;
    rst_n = 1'b0;
    level = 4'd0;
    show_alt = 1'b0;
    fill(1);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(anode == 0 && rows == 0, "R1", "drive during reset", {anode, rows}, 0);
    chk(slot_tick == 0 && frame_tick == 0, "R1", "ticks during reset", {slot_tick, frame_tick}, 0);
    shown_m = column_bits(1'b0, 0);
    shown_a = column_bits(1'b1, 0);
    col_e = 0; lvl_cur = 0; alt_cur = 1'b0; rewrote_prev = 1'b0;
    rst_n = 1'b1;
    wait_cnt = 0;
    pre_bad = 1'b0;
    while (!frame_tick && wait_cnt < 200) begin
      if (anode != 0 || rows != 0 || slot_tick) pre_bad = 1'b1;
      @(negedge clk);
      wait_cnt++;
    end
    chk(!pre_bad, "R1", "activity before first slot", pre_bad, 0);
    chk(frame_tick == 1'b1, "R4", "first frame start seen", frame_tick, 1);
    // level sweep, also across two full frames (R2 wrap, R5 all levels)
    for (int i = 1; i <= 16; i++) do_slot(i % 16, 1'b0, -1);
    // alternate buffer (R8) and back
    do_slot(7, 1'b1, -1);
    for (int i = 0; i < 9; i++) do_slot(15 - i, 1'b1, -1);
    do_slot(3, 1'b0, -1);
    do_slot(3, 1'b0, -1);
    // new buffer contents every slot (R7, R10)
    for (int s = 2; s < 20; s++) do_slot((s * 5) % 16, s[0], s);
    do_slot(0, 1'b0, -1);
    do_slot(15, 1'b0, -1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule